// File: doc/BRIEF.md
# Direct-Sequence Spreader with Bi-Phase Modulator and Rate Generator

This block takes an already scrambled serial bit stream and spreads it over a long pseudo-noise chip sequence. Each data bit is held for a fixed number of chips, and every chip is the XOR of that bit with the current pseudo-noise chip. The spread signal and the bare pseudo-noise reference are then bi-phase modulated: each is XORed with a modulator square wave that completes exactly two periods per chip.

All rates come from the single system clock through synchronous counter dividers. A step divider sets how many system cycles form one modulator step. Eight steps make one chip. The block produces two modulator square waves, one at twice the frequency of the other. On the data side it produces two single-cycle enables: one per chip, and one per data bit. The per-bit enable serves both the scrambler and the voice encoder upstream. The pseudo-noise generator is a maximal-length Fibonacci LFSR. It runs freely across data bit boundaries and restarts from its seed only on reset.

Top module: `dsss_biphase_spreader`

## Requirements
- R1: While `rst` is high, every output is 0. After `rst` falls, the first output cycle shows the modulator at phase 0 and `pn_o` equal to the MSB of the seed.
- R2: The modulator phase advances by one step every `STEP_DIV` cycles, and eight steps make one chip. `mod_fast_o` is bit 0 of the phase and toggles every step. `mod_slow_o` is bit 1 of the phase and completes exactly two periods per chip.
- R3: `chip_en_o` is a single-cycle pulse. It is high in the last output cycle of each chip, once every `8*STEP_DIV` cycles.
- R4: `bit_en_o` is high in the last output cycle of every `CHIPS_PER_BIT`-th chip, and it always coincides with `chip_en_o`.
- R5: The chip on `pn_o` is the MSB of an `LFSR_W`-bit shift register. The register shifts left and inserts bit[W-1] XOR bit[SECOND_TAP-1] at the LSB once per chip. Its period is 2^W-1 chips, and the ones in one period number 2^(W-1).
- R6: The PN register is not restarted at data bit boundaries. It continues across bits and restarts from the seed only on reset.
- R7: `data_i` is captured on the clock edge at which `bit_en_o` rises, and it is used for the next `CHIPS_PER_BIT` chips. The first data bit after reset is 0.
- R8: `spread_o` equals the current data bit XOR `pn_o`, in the same cycle.
- R9: `mod_pn_o` equals `pn_o` XOR `mod_slow_o`, and `mod_spread_o` equals `spread_o` XOR `mod_slow_o`, in the same cycle.
- R10: `pn_o` and `spread_o` change only in the cycle that follows a `chip_en_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the single rate source |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | 1 | Scrambled serial data, captured as bit_en_o rises |
| chip_en_o | output | 1 | Pulse in the last cycle of each chip |
| bit_en_o | output | 1 | Pulse in the last cycle of each data bit (scrambler and voice encoder enable) |
| mod_fast_o | output | 1 | Modulator clock at four periods per chip |
| mod_slow_o | output | 1 | Modulator clock at two periods per chip, half of mod_fast_o |
| pn_o | output | 1 | Current pseudo-noise chip |
| spread_o | output | 1 | Data bit XOR PN chip |
| mod_pn_o | output | 1 | PN chip bi-phase modulated by mod_slow_o |
| mod_spread_o | output | 1 | Spread chip bi-phase modulated by mod_slow_o |

## Verification
The bench builds the block with a 5-bit LFSR (taps 5 and 3, seed 1), a step divider of 2 and 4 chips per bit. The short 31-chip period allows whole-period checks of the sequence and its ones count within a few thousand cycles. Because 31 is not a multiple of 4, every bit boundary falls at a different LFSR state, which exposes any restart at a bit edge. A step divider above 1 exercises the divider's hold cycles.

// File: rtl/dsss_pkg.sv
package dsss_pkg;
  // eight modulator steps form one chip
  localparam int PHASE_W = 3;
  typedef logic [PHASE_W-1:0] phase_t;

  typedef struct packed {
    logic chip_en;
    logic bit_en;
    logic mod_fast;
    logic mod_slow;
  } rate_t;
endpackage

// File: rtl/dsss_rate_gen.sv
module dsss_rate_gen
  import dsss_pkg::*;
#(
  parameter int STEP_DIV      = 4,
  parameter int CHIPS_PER_BIT = 64
) (
  input  logic  clk,
  input  logic  rst,
  output rate_t rate
);
  localparam int CW = (CHIPS_PER_BIT > 1) ? $clog2(CHIPS_PER_BIT) : 1;
  localparam phase_t LAST_PHASE = '1;

  logic          tick;
  phase_t        phase;
  logic [CW-1:0] chip_cnt;
  logic          chip_last;

  generate
    if (STEP_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int QW = $clog2(STEP_DIV);
      logic [QW-1:0] step_cnt;
      always_ff @(posedge clk) begin
        if (rst) step_cnt <= '0;
        else if (step_cnt == QW'(STEP_DIV - 1)) step_cnt <= '0;
        else step_cnt <= step_cnt + 1'b1;
      end
      assign tick = (step_cnt == QW'(STEP_DIV - 1));
    end
  endgenerate

  assign chip_last = tick && (phase == LAST_PHASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      chip_cnt <= '0;
    end else begin
      if (tick) phase <= phase + 1'b1;
      if (chip_last) begin
        if (chip_cnt == CW'(CHIPS_PER_BIT - 1)) chip_cnt <= '0;
        else chip_cnt <= chip_cnt + 1'b1;
      end
    end
  end

  assign rate.chip_en  = chip_last;
  assign rate.bit_en   = chip_last && (chip_cnt == CW'(CHIPS_PER_BIT - 1));
  assign rate.mod_fast = phase[0];
  assign rate.mod_slow = phase[1];

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase));

  // R3
  chip_single_chk: assert property (@(posedge clk) disable iff (rst)
    rate.chip_en |=> !rate.chip_en);

  // R4
  bit_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    rate.bit_en |=> (chip_cnt == '0));
endmodule

// File: rtl/dsss_pn_lfsr.sv
module dsss_pn_lfsr #(
  parameter int              LFSR_W     = 15,
  parameter int              SECOND_TAP = 14,
  parameter logic [LFSR_W-1:0] SEED     = LFSR_W'(1)
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic chip
);
  logic [LFSR_W-1:0] state;
  logic              feedback;

  assign feedback = state[LFSR_W-1] ^ state[SECOND_TAP-1];
  assign chip     = state[LFSR_W-1];

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else if (step) state <= {state[LFSR_W-2:0], feedback};
  end

  // R5
  lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  // R6
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state));
endmodule

// File: rtl/dsss_spread_mod.sv
module dsss_spread_mod
  import dsss_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  rate_t rate,
  input  logic  pn_chip,
  input  logic  data_i,
  output logic  chip_en_o,
  output logic  bit_en_o,
  output logic  mod_fast_o,
  output logic  mod_slow_o,
  output logic  pn_o,
  output logic  spread_o,
  output logic  mod_pn_o,
  output logic  mod_spread_o
);
  logic data_bit;
  logic spread_c;

  assign spread_c = data_bit ^ pn_chip;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_bit     <= 1'b0;
      chip_en_o    <= 1'b0;
      bit_en_o     <= 1'b0;
      mod_fast_o   <= 1'b0;
      mod_slow_o   <= 1'b0;
      pn_o         <= 1'b0;
      spread_o     <= 1'b0;
      mod_pn_o     <= 1'b0;
      mod_spread_o <= 1'b0;
    end else begin
      if (rate.bit_en) data_bit <= data_i;
      chip_en_o    <= rate.chip_en;
      bit_en_o     <= rate.bit_en;
      mod_fast_o   <= rate.mod_fast;
      mod_slow_o   <= rate.mod_slow;
      pn_o         <= pn_chip;
      spread_o     <= spread_c;
      mod_pn_o     <= pn_chip ^ rate.mod_slow;
      mod_spread_o <= spread_c ^ rate.mod_slow;
    end
  end

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rate.bit_en |=> $stable(data_bit));

  // R9
  biphase_chk: assert property (@(posedge clk) disable iff (rst)
    (mod_pn_o == (pn_o ^ mod_slow_o)) && (mod_spread_o == (spread_o ^ mod_slow_o)));

  // R10
  chip_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!chip_en_o && !$past(rst)) |=> ($stable(pn_o) && $stable(spread_o)));
endmodule

// File: rtl/dsss_biphase_spreader.sv
module dsss_biphase_spreader
  import dsss_pkg::*;
#(
  parameter int                LFSR_W        = 15,
  parameter int                SECOND_TAP    = 14,
  parameter logic [LFSR_W-1:0] SEED          = LFSR_W'(1),
  parameter int                STEP_DIV      = 4,
  parameter int                CHIPS_PER_BIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic data_i,
  output logic chip_en_o,
  output logic bit_en_o,
  output logic mod_fast_o,
  output logic mod_slow_o,
  output logic pn_o,
  output logic spread_o,
  output logic mod_pn_o,
  output logic mod_spread_o
);
  rate_t rate;
  logic  pn_chip;

  dsss_rate_gen #(
    .STEP_DIV      (STEP_DIV),
    .CHIPS_PER_BIT (CHIPS_PER_BIT)
  ) u_rate (
    .clk  (clk),
    .rst  (rst),
    .rate (rate)
  );

  dsss_pn_lfsr #(
    .LFSR_W     (LFSR_W),
    .SECOND_TAP (SECOND_TAP),
    .SEED       (SEED)
  ) u_pn (
    .clk  (clk),
    .rst  (rst),
    .step (rate.chip_en),
    .chip (pn_chip)
  );

  dsss_spread_mod u_mod (
    .clk          (clk),
    .rst          (rst),
    .rate         (rate),
    .pn_chip      (pn_chip),
    .data_i       (data_i),
    .chip_en_o    (chip_en_o),
    .bit_en_o     (bit_en_o),
    .mod_fast_o   (mod_fast_o),
    .mod_slow_o   (mod_slow_o),
    .pn_o         (pn_o),
    .spread_o     (spread_o),
    .mod_pn_o     (mod_pn_o),
    .mod_spread_o (mod_spread_o)
  );
endmodule

// File: tb/test_dsss_biphase_spreader.sv
module test_dsss_biphase_spreader;
  localparam int       CLK_PERIOD = 10;
  localparam int       B_W        = 5;
  localparam int       B_TAP      = 3;
  localparam logic [B_W-1:0] B_SEED = 5'd1;
  localparam int       B_Q        = 2;
  localparam int       B_CPB      = 4;
  localparam int       CHIP_CYC   = 8 * B_Q;
  localparam int       BIT_CYC    = CHIP_CYC * B_CPB;
  localparam int       PERIOD     = (1 << B_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_i = 1'b0;
  logic chip_en_o, bit_en_o, mod_fast_o, mod_slow_o;
  logic pn_o, spread_o, mod_pn_o, mod_spread_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dsss_biphase_spreader #(
    .LFSR_W        (B_W),
    .SECOND_TAP    (B_TAP),
    .SEED          (B_SEED),
    .STEP_DIV      (B_Q),
    .CHIPS_PER_BIT (B_CPB)
  ) i_dsss_biphase_spreader (
    .clk          (clk),
    .rst          (rst),
    .data_i       (data_i),
    .chip_en_o    (chip_en_o),
    .bit_en_o     (bit_en_o),
    .mod_fast_o   (mod_fast_o),
    .mod_slow_o   (mod_slow_o),
    .pn_o         (pn_o),
    .spread_o     (spread_o),
    .mod_pn_o     (mod_pn_o),
    .mod_spread_o (mod_spread_o)
  );

  task automatic chk(input logic act, input logic exp, input string req, input int cyc);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", req, cyc, act, exp);
    end
  endtask

  function automatic logic pat_bit(input int mode, input int k);
    case (mode)
      0: return 1'b0;
      1: return 1'b1;
      2: return k[0];
      default: return ((k * 7 + 3) % 5) < 2;
    endcase
  endfunction

  // R1: reset holds every output low, checked after several reset cycles
  task automatic do_reset();
    rst = 1'b1;
    data_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(chip_en_o, 1'b0, "R1 chip_en", 0);
    chk(bit_en_o, 1'b0, "R1 bit_en", 0);
    chk(mod_fast_o, 1'b0, "R1 mod_fast", 0);
    chk(mod_slow_o, 1'b0, "R1 mod_slow", 0);
    chk(pn_o, 1'b0, "R1 pn", 0);
    chk(spread_o, 1'b0, "R1 spread", 0);
    chk(mod_pn_o, 1'b0, "R1 mod_pn", 0);
    chk(mod_spread_o, 1'b0, "R1 mod_spread", 0);
  endtask

  // Drives a data pattern and compares every output cycle against the model
  task automatic run_stream(input int mode, input int ncyc);
    logic [B_W-1:0] st;
    logic exp_data;
    int k;
    int p, c;
    logic e_fast, e_slow, e_cen, e_ben, e_pn, e_sp;
    do_reset();
    st = B_SEED;
    exp_data = 1'b0;
    k = 1;
    data_i = pat_bit(mode, 1);
    rst = 1'b0;
    for (int m = 0; m < ncyc; m++) begin
      @(posedge clk);
      @(negedge clk);
      p = (m / B_Q) % 8;
      c = m / CHIP_CYC;
      e_fast = p[0];
      e_slow = p[1];
      e_cen = ((m % CHIP_CYC) == CHIP_CYC - 1);
      e_ben = ((m % BIT_CYC) == BIT_CYC - 1);
      e_pn = st[B_W-1];
      e_sp = exp_data ^ e_pn;
      if (m == 0) chk(pn_o, B_SEED[B_W-1], "R1 first chip", m);
      chk(mod_fast_o, e_fast, "R2 mod_fast", m);
      chk(mod_slow_o, e_slow, "R2 mod_slow", m);
      chk(chip_en_o, e_cen, "R3 chip_en", m);
      chk(bit_en_o, e_ben, "R4 bit_en", m);
      if (c < B_CPB) chk(pn_o, e_pn, "R5 pn chip", m);
      else chk(pn_o, e_pn, "R6 pn across bits", m);
      if (m >= BIT_CYC) chk(spread_o, e_sp, "R7 data held in spread", m);
      else chk(spread_o, e_sp, "R8 spread", m);
      chk(mod_pn_o, e_pn ^ e_slow, "R9 mod_pn", m);
      chk(mod_spread_o, e_sp ^ e_slow, "R9 mod_spread", m);
      if (e_cen) st = {st[B_W-2:0], st[B_W-1] ^ st[B_TAP-1]};
      if (e_ben) begin
        exp_data = data_i;
        k++;
        data_i = pat_bit(mode, k);
      end
    end
  endtask

  // R5: two full periods of chips, period repetition and balance
  task automatic check_period();
    logic chips [2*PERIOD];
    int n, ones;
    do_reset();
    rst = 1'b0;
    n = 0;
    while (n < 2 * PERIOD) begin
      @(posedge clk);
      @(negedge clk);
      if (chip_en_o) begin
        chips[n] = pn_o;
        n++;
      end
    end
    ones = 0;
    for (int i = 0; i < PERIOD; i++) begin
      if (chips[i]) ones++;
      chk(chips[i + PERIOD], chips[i], "R5 period repeat", i);
    end
    checks++;
    if (ones != (1 << (B_W - 1))) begin
      errors++;
      $display("FAIL R5 ones per period: actual %0d expected %0d", ones, 1 << (B_W - 1));
    end
  endtask

  // R10: pn_o and spread_o stay put except right after chip_en_o
  task automatic check_chip_alignment();
    logic prev_pn, prev_sp, prev_cen;
    do_reset();
    data_i = 1'b1;
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    prev_pn = pn_o;
    prev_sp = spread_o;
    prev_cen = chip_en_o;
    for (int m = 1; m < 6 * BIT_CYC; m++) begin
      @(posedge clk);
      @(negedge clk);
      if (!prev_cen) begin
        chk(pn_o, prev_pn, "R10 pn steady", m);
        chk(spread_o, prev_sp, "R10 spread steady", m);
      end
      data_i = ~data_i;
      prev_pn = pn_o;
      prev_sp = spread_o;
      prev_cen = chip_en_o;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    run_stream(0, 8 * BIT_CYC);
    run_stream(1, 8 * BIT_CYC);
    run_stream(2, 12 * BIT_CYC);
    run_stream(3, 40 * BIT_CYC);
    run_stream(3, 3 * BIT_CYC + 7);   // reset mid-bit, then restart
    run_stream(2, 4 * BIT_CYC);
    check_period();
    check_chip_alignment();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule